// File: doc/BRIEF.md
# I2C Byte-Command Master

This block is the host side of a two-wire serial bus. Software drives it through a small register port and moves exactly one byte per command. A command word can ask for a start (or repeated start) condition before the byte, a stop condition after the byte's acknowledge slot, and a not-acknowledge in place of an acknowledge when a byte is received. After every byte the block reports that the byte is done, and whether a not-acknowledge was seen or sent. It then waits with SCL held low for the next command, or it releases the bus after a stop.

The SCL rate comes from an 18-bit divider field and a glitch-allowance field. The low phase lasts `div+2+gsr` clock cycles and the high phase lasts `div+2` cycles, so one bit takes `2*(div+2)+gsr` cycles. A self-clearing reset bit in the command register sends the block back to idle.

Register addresses: 0 command (bit0 enable, bit1 transfer, bit2 start, bit3 stop, bit4 nak, bit5 soft reset), 1 status (bit0 byte sent, bit1 byte received, bit2 not-acknowledge, bit3 busy), 2 data (low 8 bits), 3 divider (bits 17:0), 4 timing (glitch allowance in bits 7:0, hold setting in bits 23:16).

The states are ST_IDLE, ST_RST, ST_RS_LOW, ST_ST_HIGH, ST_ST_HOLD, ST_BIT_LOW, ST_BIT_HIGH, ST_ACK_LOW, ST_ACK_HIGH, ST_PARK, ST_SP_LOW, ST_SP_HIGH and ST_SP_REL. The transitions are:

- A start command in ST_IDLE goes to ST_ST_HIGH.
- A start command in ST_PARK goes to ST_RS_LOW, then to ST_ST_HIGH.
- ST_ST_HIGH goes to ST_ST_HOLD, which drops SDA, and then to ST_BIT_LOW.
- ST_BIT_LOW and ST_BIT_HIGH alternate eight times, then the block enters ST_ACK_LOW and ST_ACK_HIGH.
- ST_ACK_HIGH goes to ST_SP_LOW, ST_SP_HIGH, ST_SP_REL and then ST_IDLE when a stop was asked for and no not-acknowledge came back. Otherwise it goes to ST_PARK.
- A command without a start in ST_PARK goes to ST_BIT_LOW.
- The reset bit sends any state to ST_RST, which returns to ST_IDLE.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the block has both lines released (scl_out=1, sda_out=1). Command readback is 0, status is 0, divider is 0 and timing reads 0x00200000 (hold setting 32 in bits 23:16).
- R2: Each SCL low phase lasts div+2+gsr cycles and each high phase lasts div+2 cycles.
- R3: Divider bits above bit 17 are dropped, so writing all ones reads 0x3FFFF. Timing keeps bits 7:0 and 23:16. Divider and timing writes are ignored while status bit3 (busy) is 1.
- R4: A command with bits 0, 1 and 2 set, given in idle, produces a start condition (SDA falls while SCL is high) and then sends the data register MSB first.
- R5: Bit0 of the byte sent after a start selects the direction. When it is 1, later commands without a start receive bytes.
- R6: After a sent byte's acknowledge slot, status bit0 sets. Status bit2 also sets if the target left SDA high in that slot.
- R7: After a not-acknowledge on a sent byte, the block holds SCL low and skips any requested stop until the next command.
- R8: A received byte sets status bit1 and appears in data register bits 7:0. The block drives SDA low in the acknowledge slot, unless command bit4 is set. With bit4 set it leaves SDA high and sets status bit2.
- R9: With command bit3 set, a stop condition (SDA rises while SCL is high) follows the acknowledge slot. Afterwards both lines are released and busy clears.
- R10: A start command given while waiting with SCL low produces a repeated start, with no stop in between.
- R11: Writing command bit5 makes bit5 read 1 for RST_CYCLES cycles, then 0. The block ends in idle with the bus released and status cleared.
- R12: An accepted command clears status bits 0 to 2. A command without a start given in idle is ignored: no SCL activity and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | peripheral clock |
| rst_n | input | 1 | active-low asynchronous-free synchronous reset |
| reg_wen | input | 1 | register write strobe |
| reg_addr | input | 3 | register address for read and write |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data (combinational on reg_addr) |
| scl_out | output | 1 | SCL drive, 1 = released, 0 = pulled low |
| sda_out | output | 1 | SDA drive, 1 = released, 0 = pulled low |
| sda_in | input | 1 | sampled SDA line level |

## Verification
The assertions take for granted that the divider and timing values stay fixed while a phase is being timed. The block enforces this itself by ignoring configuration writes while busy. They also assume that the SDA line only changes while SCL is low, except at start and stop conditions. The bench's target model keeps to this: it changes SDA only after it sees a falling SCL edge. It writes commands only when status shows the block idle or parked, apart from the one deliberate write during a transfer.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST,
        ST_RS_LOW,
        ST_ST_HIGH,
        ST_ST_HOLD,
        ST_BIT_LOW,
        ST_BIT_HIGH,
        ST_ACK_LOW,
        ST_ACK_HIGH,
        ST_PARK,
        ST_SP_LOW,
        ST_SP_HIGH,
        ST_SP_REL
    } mst_state_t;

    // command word bit positions
    localparam int unsigned CMD_EN    = 0;
    localparam int unsigned CMD_XFER  = 1;
    localparam int unsigned CMD_START = 2;
    localparam int unsigned CMD_STOP  = 3;
    localparam int unsigned CMD_NAK   = 4;
    localparam int unsigned CMD_RST   = 5;

    // register addresses
    localparam logic [2:0] RA_CMD  = 3'd0;
    localparam logic [2:0] RA_STAT = 3'd1;
    localparam logic [2:0] RA_DATA = 3'd2;
    localparam logic [2:0] RA_DIV  = 3'd3;
    localparam logic [2:0] RA_TIM  = 3'd4;

endpackage

// File: rtl/i2cbm_phase_timer.sv
module i2cbm_phase_timer #(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] len,
    output logic          phase_end
);

    logic [CW-1:0] cnt_q;

    assign phase_end = run && (cnt_q == len - CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || phase_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // phase counter never passes the programmed phase length
    assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < len));

endmodule

// File: rtl/i2cbm_csr.sv
module i2cbm_csr
    import i2cbm_pkg::*;
#(
    parameter int DIV_W    = 18,
    parameter int GSR_W    = 8,
    parameter int TSR_W    = 8,
    parameter int TSR_INIT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wen,
    input  logic [2:0]       addr,
    input  logic [31:0]      wdata,
    input  logic             cfg_lock,
    input  logic [5:0]       cmd_view,
    input  logic [3:0]       stat_view,
    input  logic [7:0]       data_view,
    output logic [DIV_W-1:0] div_q,
    output logic [GSR_W-1:0] gsr_q,
    output logic [31:0]      rdata
);

    localparam int TSR_LSB = 16;

    logic [TSR_W-1:0] tsr_q;
    logic             unused_wbits;

    assign unused_wbits = ^{wdata[31:TSR_LSB+TSR_W], wdata[TSR_LSB-1:GSR_W]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            gsr_q <= '0;
            tsr_q <= TSR_W'(TSR_INIT);
        end else if (wen && !cfg_lock) begin
            if (addr == RA_DIV) begin
                div_q <= wdata[DIV_W-1:0];
            end
            if (addr == RA_TIM) begin
                gsr_q <= wdata[GSR_W-1:0];
                tsr_q <= wdata[TSR_LSB +: TSR_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_CMD:  rdata[5:0] = cmd_view;
            RA_STAT: rdata[3:0] = stat_view;
            RA_DATA: rdata[7:0] = data_view;
            RA_DIV:  rdata[DIV_W-1:0] = div_q;
            RA_TIM: begin
                rdata[GSR_W-1:0]         = gsr_q;
                rdata[TSR_LSB +: TSR_W]  = tsr_q;
            end
            default: rdata = '0;
        endcase
    end

    // configuration must not move while a phase is being timed
    assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_lock) && cfg_lock) |-> ($stable(div_q) && $stable(gsr_q)));

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cbm_pkg::*;
#(
    parameter int DIV_W      = 18,
    parameter int GSR_W      = 8,
    parameter int TSR_W      = 8,
    parameter int RST_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wen,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        scl_out,
    output logic        sda_out,
    input  logic        sda_in
);

    localparam int CW  = DIV_W + 2;
    localparam int RCW = $clog2(RST_CYCLES + 1);

    mst_state_t       state_q, state_d;
    logic [2:0]       bit_q;
    logic [7:0]       sh_q, data_q;
    logic             dir_rx_q, addr_ph_q, dir_pend_q, stop_q, nak_q;
    logic [4:0]       cmd_q;
    logic             sta_txd_q, sta_rxd_q, sta_nak_q;
    logic [RCW-1:0]   rcnt_q;
    logic [DIV_W-1:0] div_q;
    logic [GSR_W-1:0] gsr_q;
    logic [CW-1:0]    low_len, high_len, phase_len;
    logic             phase_end, run, busy, cur_rx, scl_low_phase;
    logic             cmd_wr, soft_rst, can_take, accept, nack_in, rst_done;

    assign cmd_wr   = reg_wen && (reg_addr == RA_CMD);
    assign soft_rst = cmd_wr && reg_wdata[CMD_RST];
    assign can_take = ((state_q == ST_IDLE) && reg_wdata[CMD_START]) || (state_q == ST_PARK);
    assign accept   = cmd_wr && !reg_wdata[CMD_RST] && reg_wdata[CMD_EN]
                      && reg_wdata[CMD_XFER] && can_take;
    assign cur_rx   = dir_rx_q && !addr_ph_q;
    assign busy     = !((state_q == ST_IDLE) || (state_q == ST_PARK));
    assign run      = busy && (state_q != ST_RST);
    assign nack_in  = !cur_rx && sda_in;
    assign rst_done = (rcnt_q == RCW'(RST_CYCLES - 1));

    assign scl_low_phase = (state_q == ST_RS_LOW) || (state_q == ST_BIT_LOW)
                        || (state_q == ST_ACK_LOW) || (state_q == ST_SP_LOW);
    assign low_len   = CW'(div_q) + CW'(gsr_q) + CW'(2);
    assign high_len  = CW'(div_q) + CW'(2);
    assign phase_len = scl_low_phase ? low_len : high_len;

    i2cbm_phase_timer #(.CW(CW)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .len       (phase_len),
        .phase_end (phase_end)
    );

    i2cbm_csr #(.DIV_W(DIV_W), .GSR_W(GSR_W), .TSR_W(TSR_W), .TSR_INIT(32)) csr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wen       (reg_wen),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .cfg_lock  (busy),
        .cmd_view  ({state_q == ST_RST, cmd_q}),
        .stat_view ({busy, sta_nak_q, sta_rxd_q, sta_txd_q}),
        .data_view (data_q),
        .div_q     (div_q),
        .gsr_q     (gsr_q),
        .rdata     (reg_rdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_d = ST_ST_HIGH;
            ST_PARK:     if (accept) state_d = reg_wdata[CMD_START] ? ST_RS_LOW : ST_BIT_LOW;
            ST_RST:      if (rst_done) state_d = ST_IDLE;
            ST_RS_LOW:   if (phase_end) state_d = ST_ST_HIGH;
            ST_ST_HIGH:  if (phase_end) state_d = ST_ST_HOLD;
            ST_ST_HOLD:  if (phase_end) state_d = ST_BIT_LOW;
            ST_BIT_LOW:  if (phase_end) state_d = ST_BIT_HIGH;
            ST_BIT_HIGH: if (phase_end) state_d = (bit_q == 3'd0) ? ST_ACK_LOW : ST_BIT_LOW;
            ST_ACK_LOW:  if (phase_end) state_d = ST_ACK_HIGH;
            ST_ACK_HIGH: if (phase_end) state_d = (stop_q && !nack_in) ? ST_SP_LOW : ST_PARK;
            ST_SP_LOW:   if (phase_end) state_d = ST_SP_HIGH;
            ST_SP_HIGH:  if (phase_end) state_d = ST_SP_REL;
            ST_SP_REL:   if (phase_end) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
        if (soft_rst) state_d = ST_RST;
    end

    // byte datapath and status
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            bit_q      <= '0;
            sh_q       <= '0;
            data_q     <= '0;
            dir_rx_q   <= 1'b0;
            addr_ph_q  <= 1'b0;
            dir_pend_q <= 1'b0;
            stop_q     <= 1'b0;
            nak_q      <= 1'b0;
            cmd_q      <= '0;
            sta_txd_q  <= 1'b0;
            sta_rxd_q  <= 1'b0;
            sta_nak_q  <= 1'b0;
            rcnt_q     <= '0;
        end else begin
            rcnt_q <= (state_q == ST_RST) ? RCW'(rcnt_q + RCW'(1)) : '0;
            if (reg_wen && (reg_addr == RA_DATA)) begin
                data_q <= reg_wdata[7:0];
            end
            if (accept) begin
                cmd_q     <= reg_wdata[4:0];
                stop_q    <= reg_wdata[CMD_STOP];
                nak_q     <= reg_wdata[CMD_NAK];
                bit_q     <= 3'd7;
                sh_q      <= data_q;
                sta_txd_q <= 1'b0;
                sta_rxd_q <= 1'b0;
                sta_nak_q <= 1'b0;
                addr_ph_q <= reg_wdata[CMD_START];
                if (reg_wdata[CMD_START]) begin
                    dir_pend_q <= data_q[0];
                end
            end
            if ((state_q == ST_BIT_HIGH) && phase_end) begin
                sh_q  <= {sh_q[6:0], sda_in};
                bit_q <= 3'(bit_q - 3'd1);
            end
            if ((state_q == ST_ACK_HIGH) && phase_end) begin
                if (cur_rx) begin
                    sta_rxd_q <= 1'b1;
                    data_q    <= sh_q;
                    if (nak_q) sta_nak_q <= 1'b1;
                end else begin
                    sta_txd_q <= 1'b1;
                    if (sda_in) sta_nak_q <= 1'b1;
                end
                if (addr_ph_q) begin
                    dir_rx_q  <= dir_pend_q;
                    addr_ph_q <= 1'b0;
                end
            end
        end
    end

    // line outputs
    always_comb begin
        scl_out = !scl_low_phase && (state_q != ST_PARK);
        unique case (state_q)
            ST_ST_HOLD, ST_SP_LOW, ST_SP_HIGH: sda_out = 1'b0;
            ST_BIT_LOW, ST_BIT_HIGH:           sda_out = cur_rx ? 1'b1 : sh_q[7];
            ST_ACK_LOW, ST_ACK_HIGH:           sda_out = cur_rx ? nak_q : 1'b1;
            default:                           sda_out = 1'b1;
        endcase
    end

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (scl_out && sda_out));

    assert_sda_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_BIT_HIGH) && ($past(state_q) == ST_BIT_HIGH)) |-> $stable(sda_out));

    assert_done_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sta_txd_q && sta_rxd_q));

    assert_park_holds_scl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARK) |-> !scl_out);

    assert_reset_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RST) |-> (rcnt_q < RCW'(RST_CYCLES)));

    assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_SP_REL && state_q == ST_IDLE) |-> (scl_out && sda_out));

endmodule

// File: tb/i2c_byte_master_tb_top.sv
`timescale 1ns/1ps
module i2c_byte_master_tb_top;

    localparam int RSTC = 4;
    localparam logic [2:0] A_CMD = 3'd0, A_STAT = 3'd1, A_DATA = 3'd2, A_DIV = 3'd3, A_TIM = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        scl_out, sda_out;
    logic        slave_sda = 1'b1;
    wire         sda_line = sda_out & slave_sda;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    i2c_byte_master #(.RST_CYCLES(RSTC)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .scl_out   (scl_out),
        .sda_out   (sda_out),
        .sda_in    (sda_line)
    );

    function automatic logic [7:0] rdf(int i);
        return 8'(8'h3C + i * 8'h47);
    endfunction

    // target model
    logic       p_scl = 1'b1, p_sda = 1'b1, first = 1'b0, s_rd = 1'b0, mack = 1'b0, s_ack_en = 1'b1;
    logic [7:0] sh = '0, got_addr = '0, got_data = '0, v;
    int         bitpos = 0, rd_idx = 0, start_cnt = 0, stop_cnt = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            slave_sda = 1'b1; p_scl = 1'b1; p_sda = 1'b1; s_rd = 1'b0; bitpos = 0;
        end else begin
            if (p_scl && scl_out && p_sda && !sda_line) begin
                start_cnt++; bitpos = -1; first = 1'b1; s_rd = 1'b0; rd_idx = 0; slave_sda = 1'b1;
            end else if (p_scl && scl_out && !p_sda && sda_line) begin
                stop_cnt++; slave_sda = 1'b1; s_rd = 1'b0;
            end else if (!p_scl && scl_out) begin
                if (bitpos >= 0 && bitpos < 8) sh = {sh[6:0], sda_line};
                else if (bitpos == 8 && s_rd) mack = sda_line;
            end else if (p_scl && !scl_out) begin
                bitpos++;
                if (bitpos == 8) begin
                    if (!s_rd) begin
                        if (first) got_addr = sh; else got_data = sh;
                        slave_sda = s_ack_en ? 1'b0 : 1'b1;
                    end else begin
                        slave_sda = 1'b1;
                    end
                end else if (bitpos == 9) begin
                    bitpos = 0;
                    if (first) begin
                        first = 1'b0; s_rd = got_addr[0];
                    end else if (s_rd) begin
                        rd_idx++;
                        if (mack) s_rd = 1'b0;
                    end
                    v = rdf(rd_idx);
                    slave_sda = s_rd ? v[7] : 1'b1;
                end else if (s_rd) begin
                    v = rdf(rd_idx);
                    slave_sda = v[7-bitpos];
                end
            end
            p_scl = scl_out;
            p_sda = scl_out & sda_out & slave_sda | (!scl_out & sda_out & slave_sda);
        end
    end

    // SCL phase length monitor
    logic m_prev = 1'b1;
    int   run_len = 0, hi_len = 0, lo_len = 0, lo_count = 0;
    always @(negedge clk) begin
        if (!scl_out) lo_count++;
        if (scl_out != m_prev) begin
            if (m_prev) hi_len = run_len; else lo_len = run_len;
            run_len = 1;
        end else begin
            run_len++;
        end
        m_prev = scl_out;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_free();
        logic [31:0] s;
        int n = 0;
        rd(A_STAT, s);
        while (s[3] && n < 20000) begin
            @(negedge clk);
            rd(A_STAT, s);
            n++;
        end
        if (s[3]) chk("busy timeout", 32'(s[3]), 32'd0);
    endtask

    initial begin
        #(200000 * 20);
        errors++; checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int sc, pc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(A_CMD, r);  chk("R1 cmd", r, 32'd0);
        rd(A_STAT, r); chk("R1 status", r, 32'd0);
        rd(A_DIV, r);  chk("R1 div", r, 32'd0);
        rd(A_TIM, r);  chk("R1 timing", r, 32'h0020_0000);
        chk("R1 lines", {30'd0, scl_out, sda_out}, 32'd3);

        // R3 field widths
        wr(A_DIV, 32'hFFFF_FFFF); rd(A_DIV, r); chk("R3 div width", r, 32'h0003_FFFF);
        wr(A_TIM, 32'hFFFF_FFFF); rd(A_TIM, r); chk("R3 timing fields", r, 32'h00FF_00FF);

        // R2 sweep of divider and glitch allowance
        for (int d = 0; d < 6; d++) begin
            for (int g = 0; g < 4; g++) begin
                wr(A_DIV, 32'(d));
                wr(A_TIM, 32'(g) | 32'h0020_0000);
                wr(A_DATA, 32'h54);
                wr(A_CMD, 32'd15);
                wait_free();
                chk("R2 high phase", 32'(hi_len), 32'(d + 2));
                chk("R2 low phase", 32'(lo_len), 32'(d + 2 + g));
            end
        end
        chk("R4 address byte sent", 32'(got_addr), 32'h54);

        // R4 R6 R9 write burst
        wr(A_DIV, 32'd1); wr(A_TIM, 32'h0020_0000);
        sc = start_cnt; pc = stop_cnt;
        wr(A_DATA, 32'h54); wr(A_CMD, 32'd7); wait_free();
        rd(A_STAT, r); chk("R6 address done", r, 32'h1);
        chk("R4 start seen", 32'(start_cnt - sc), 32'd1);
        chk("R7 parked scl low", 32'(scl_out), 32'd0);
        for (int i = 0; i < 4; i++) begin
            logic [7:0] b;
            b = 8'(i * 8'h5B) ^ 8'hA6;
            wr(A_DATA, 32'(b));
            wr(A_CMD, (i == 3) ? 32'd11 : 32'd3);
            wait_free();
            chk("R4 data byte", 32'(got_data), 32'(b));
            rd(A_STAT, r); chk("R6 byte done", r, 32'h1);
        end
        chk("R9 stop seen", 32'(stop_cnt - pc), 32'd1);
        chk("R9 lines released", {30'd0, scl_out, sda_out}, 32'd3);

        // R12 command without start in idle is ignored
        lo_count = 0;
        wr(A_CMD, 32'd3);
        repeat (30) @(negedge clk);
        chk("R12 no scl activity", 32'(lo_count), 32'd0);
        rd(A_STAT, r); chk("R12 status kept", r, 32'h1);
        wr(A_DATA, 32'h54); wr(A_CMD, 32'd7);
        rd(A_STAT, r); chk("R12 status cleared on accept", r, 32'h8);
        wait_free();

        // R10 repeated start into a read
        sc = start_cnt; pc = stop_cnt;
        wr(A_DATA, 32'hA1); wr(A_CMD, 32'd7); wait_free();
        chk("R10 repeated start", 32'(start_cnt - sc), 32'd1);
        chk("R10 no stop between", 32'(stop_cnt - pc), 32'd0);
        chk("R5 read address", 32'(got_addr), 32'hA1);

        // R5 R8 receive three bytes, last with nak and stop
        for (int i = 0; i < 3; i++) begin
            wr(A_CMD, (i == 2) ? 32'd27 : 32'd3);
            wait_free();
            rd(A_DATA, r); chk("R8 received byte", r, 32'(rdf(i)));
            rd(A_STAT, r); chk("R8 status", r, (i == 2) ? 32'h6 : 32'h2);
            chk("R8 ack level driven", 32'(mack), (i == 2) ? 32'd1 : 32'd0);
        end
        chk("R9 stop after read", 32'(stop_cnt - pc), 32'd1);

        // R3 configuration locked while busy
        wr(A_DIV, 32'd2);
        wr(A_DATA, 32'h54); wr(A_CMD, 32'd15);
        wr(A_DIV, 32'd9);
        wait_free();
        rd(A_DIV, r); chk("R3 div locked while busy", r, 32'd2);

        // R7 not-acknowledge parks and skips stop
        s_ack_en = 1'b0;
        pc = stop_cnt;
        wr(A_DATA, 32'h54); wr(A_CMD, 32'd15); wait_free();
        rd(A_STAT, r); chk("R6 nak status", r, 32'h5);
        repeat (40) @(negedge clk);
        chk("R7 scl held low", 32'(scl_out), 32'd0);
        chk("R7 no stop", 32'(stop_cnt - pc), 32'd0);
        s_ack_en = 1'b1;

        // R11 soft reset
        wr(A_CMD, 32'd32);
        rd(A_CMD, r); chk("R11 reset bit set", 32'(r[5]), 32'd1);
        repeat (RSTC - 1) @(negedge clk);
        rd(A_CMD, r); chk("R11 reset bit held", 32'(r[5]), 32'd1);
        @(negedge clk);
        rd(A_CMD, r); chk("R11 reset bit cleared", 32'(r[5]), 32'd0);
        rd(A_STAT, r); chk("R11 status cleared", r, 32'd0);
        chk("R11 lines released", {30'd0, scl_out, sda_out}, 32'd3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule